// File: doc/BRIEF.md
# DMA Channel Control Register File

This block is the software-visible control section of a single DMA channel. It holds four 32-bit words: a control/status word, a current transfer address, a byte count and an address base. Software reaches them with whole-word reads and writes. The register index comes from address bits [3:2], so the block decodes correctly at any 16-byte-aligned base.

Writes to the control word have side effects:
- A fixed version code is stamped into the top nibble.
- A write of zero becomes a drain request.
- A device-reset bit fires a one-cycle pulse toward the attached peripheral.

Writing the address word sets an address-loaded flag in the control word.

The peripheral side has two inputs. A level interrupt request sets or clears the pending flag on its edges. A transfer-done strobe with a byte length advances the address word and marks an interrupt pending. The interrupt output is the pending flag gated by the enable bit.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the control word reads 0xA0000000, the other three words read 0, and both `irq_o` and `periph_rst_o` are low.
- R2: The word index is address bits [3:2] and all other address bits are ignored. Index 0 is control, 1 is address, 2 is count and 3 is base. Indices 2 and 3 store the written value unchanged.
- R3: Every control write stores 0xA in bits [31:28] and keeps the written bits [27:0], except for the changes to bit 6 stated in R4.
- R4: A control write of exactly zero stores bit 6 (drain) set. When bit 7 is clear and bit 6 is set in a control write, bit 6 is stored clear. When bit 7 is set, bit 6 is stored as written.
- R5: A control write with bit 7 set drives `periph_rst_o` high for exactly the one cycle after the write edge.
- R6: A write to index 1 sets control bit 26 (address loaded) at the same edge, and control bit 26 stays set until a later control write rewrites it.
- R7: A rising edge on `irq_req_i` sets control bit 0 (pending) one edge later. A falling edge clears it one edge later.
- R8: `irq_o` is high exactly when control bit 0 and control bit 4 (enable) are both set. A control write with bit 4 clear therefore leaves `irq_o` low after that edge.
- R9: A `xfer_done_i` strobe adds the zero-extended `xfer_len_i` to the address word and sets control bit 0, both at the same edge.
- R10: When a software write to index 1 and a `xfer_done_i` strobe fall in the same cycle, the address word takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Word write strobe |
| bus_addr_i | input | ADDR_W | Byte address; bits [3:2] select the word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the word selected by `bus_addr_i` (combinational) |
| irq_req_i | input | 1 | Interrupt request level from the peripheral |
| xfer_done_i | input | 1 | Transfer-complete strobe |
| xfer_len_i | input | LEN_W | Bytes moved by the completed transfer |
| irq_o | output | 1 | Interrupt output |
| periph_rst_o | output | 1 | One-cycle reset pulse to the peripheral |

## Verification
A corrupted control word shows up on `bus_rdata_o` in the cycle after the faulty edge. A wrong pending or enable bit shows up on `irq_o` in that same cycle, since `irq_o` has no register between it and the control word. A slip in the edge detector for the interrupt request either lags `irq_o` by a cycle or misses an edge entirely. A stale address word becomes visible on the first read after a transfer-done strobe. A misrouted reset bit appears as a missing or stretched pulse on `periph_rst_o` one edge after the write.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 16,
  parameter logic [3:0] VERSION = 4'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              irq_req_i,
  input  logic              xfer_done_i,
  input  logic [LEN_W-1:0]  xfer_len_i,
  output logic              irq_o,
  output logic              periph_rst_o
);
  localparam int B_PEND  = 0;
  localparam int B_IEN   = 4;
  localparam int B_DRAIN = 6;
  localparam int B_DRST  = 7;
  localparam int B_LOAD  = 26;
  localparam logic [31:0] CTRL_RST = {VERSION, 28'h0};

  logic [31:0] ctrl_q, addr_q, cnt_q, base_q;
  logic        req_q;
  logic [1:0]  idx;

  assign idx = bus_addr_i[3:2];

  wire wr_ctrl = bus_wr_i && idx == 2'd0;
  wire wr_addr = bus_wr_i && idx == 2'd1;
  wire req_rise = irq_req_i && !req_q;
  wire req_fall = !irq_req_i && req_q;

  function automatic logic [31:0] shape_ctrl(input logic [31:0] v);
    logic [31:0] r;
    r = v;
    if (!v[B_DRST]) begin
      if (v[B_DRAIN])   r[B_DRAIN] = 1'b0;
      else if (v == '0) r[B_DRAIN] = 1'b1;
    end
    r[31:28] = VERSION;
    return r;
  endfunction

  logic [31:0] ctrl_d;
  always_comb begin
    ctrl_d = wr_ctrl ? shape_ctrl(bus_wdata_i) : ctrl_q;
    if (wr_addr) ctrl_d[B_LOAD] = 1'b1;
    if (req_rise || xfer_done_i) ctrl_d[B_PEND] = 1'b1;
    else if (req_fall) ctrl_d[B_PEND] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q       <= CTRL_RST;
      addr_q       <= '0;
      cnt_q        <= '0;
      base_q       <= '0;
      req_q        <= 1'b0;
      periph_rst_o <= 1'b0;
    end else begin
      ctrl_q       <= ctrl_d;
      req_q        <= irq_req_i;
      periph_rst_o <= wr_ctrl && bus_wdata_i[B_DRST];
      if (wr_addr)          addr_q <= bus_wdata_i;
      else if (xfer_done_i) addr_q <= addr_q + 32'(xfer_len_i);
      if (bus_wr_i && idx == 2'd2) cnt_q  <= bus_wdata_i;
      if (bus_wr_i && idx == 2'd3) base_q <= bus_wdata_i;
    end
  end

  always_comb begin
    unique case (idx)
      2'd0: bus_rdata_o = ctrl_q;
      2'd1: bus_rdata_o = addr_q;
      2'd2: bus_rdata_o = cnt_q;
      default: bus_rdata_o = base_q;
    endcase
  end

  assign irq_o = ctrl_q[B_PEND] & ctrl_q[B_IEN];
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_wdata_i,
  input logic              xfer_done_i,
  input logic [LEN_W-1:0]  xfer_len_i,
  input logic              irq_o,
  input logic              periph_rst_o,
  input logic [31:0]       ctrl_q,
  input logic [31:0]       addr_q
);
  p_version_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[31:28] == 4'hA);

  p_pulse_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst_o |-> $past(bus_wr_i && bus_addr_i[3:2] == 2'd0 && bus_wdata_i[7]));

  p_loaded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i[3:2] == 2'd1) |=> ctrl_q[26]);

  p_irq_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i[3:2] == 2'd0 && !bus_wdata_i[4]) |=> !irq_o);

  p_advance_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done_i && !(bus_wr_i && bus_addr_i[3:2] == 2'd1))
      |=> (addr_q == $past(addr_q) + 32'($past(xfer_len_i)) && ctrl_q[0]));

  p_sw_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i[3:2] == 2'd1) |=> addr_q == $past(bus_wdata_i));
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
  .bus_wdata_i(bus_wdata_i), .xfer_done_i(xfer_done_i), .xfer_len_i(xfer_len_i),
  .irq_o(irq_o), .periph_rst_o(periph_rst_o), .ctrl_q(ctrl_q), .addr_q(addr_q)
);

// File: tb/tb_dma_chan_regs.sv
`timescale 1ns/1ps
module tb_dma_chan_regs;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, irq_req = 0, xfer_done = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, rdata;
  logic [15:0] xfer_len = '0;
  logic irq, prst;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  dma_chan_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(rdata), .irq_req_i(irq_req),
    .xfer_done_i(xfer_done), .xfer_len_i(xfer_len), .irq_o(irq), .periph_rst_o(prst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #0.5; d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h00, v); check("R1 ctrl", v, 32'hA000_0000);
    rd(8'h04, v); check("R1 addr", v, 0);
    rd(8'h08, v); check("R1 count", v, 0);
    rd(8'h0C, v); check("R1 base", v, 0);
    check("R1 irq", irq, 0);
    check("R1 prst", prst, 0);
  endtask

  task automatic t_decode;
    logic [31:0] v;
    wr(8'h48, 32'hDEAD_BEEF);
    wr(8'hFC, 32'h1234_5678);
    rd(8'h08, v); check("R2 count alias", v, 32'hDEAD_BEEF);
    rd(8'hB8, v); check("R2 count high bits", v, 32'hDEAD_BEEF);
    rd(8'h0C, v); check("R2 base", v, 32'h1234_5678);
    rd(8'h04, v); check("R2 addr untouched", v, 0);
  endtask

  task automatic t_version;
    logic [31:0] v;
    wr(8'h00, 32'hF000_0011); rd(8'h00, v); check("R3 stamp", v, 32'hA000_0011);
    wr(8'h40, 32'h5ABC_0100); rd(8'h00, v); check("R3 low kept", v, 32'hAABC_0100);
  endtask

  task automatic t_drain;
    logic [31:0] v;
    wr(8'h00, 32'h0);  rd(8'h00, v); check("R4 zero->drain", v, 32'hA000_0040);
    wr(8'h00, 32'h40); rd(8'h00, v); check("R4 drain cleared", v, 32'hA000_0000);
    wr(8'h00, 32'h50); rd(8'h00, v); check("R4 drain cleared en", v, 32'hA000_0010);
  endtask

  task automatic t_devrst;
    logic [31:0] v;
    @(negedge clk); bus_wr = 1; bus_addr = 8'h00; bus_wdata = 32'hC0;
    @(negedge clk); bus_wr = 0;
    check("R5 pulse high", prst, 1);
    rd(8'h00, v); check("R4 drain kept with reset", v, 32'hA000_00C0);
    @(negedge clk); check("R5 pulse one cycle", prst, 0);
    wr(8'h00, 32'h40); check("R5 no pulse", prst, 0);
  endtask

  task automatic t_loaded;
    logic [31:0] v;
    wr(8'h00, 32'h0);
    wr(8'h04, 32'h0000_1000);
    rd(8'h00, v); check("R6 loaded", v, 32'hA400_0040);
    wr(8'h08, 32'h1);
    rd(8'h00, v); check("R6 loaded holds", v, 32'hA400_0040);
    rd(8'h04, v); check("R6 addr", v, 32'h0000_1000);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(8'h00, 32'h10);
    check("R8 idle low", irq, 0);
    @(negedge clk); irq_req = 1;
    @(negedge clk);
    rd(8'h00, v); check("R7 rise sets", v[0], 1);
    check("R8 asserted", irq, 1);
    @(negedge clk); irq_req = 0;
    @(negedge clk);
    rd(8'h00, v); check("R7 fall clears", v[0], 0);
    check("R8 drops", irq, 0);
    @(negedge clk); irq_req = 1;
    @(negedge clk); check("R8 reasserted", irq, 1);
    wr(8'h00, 32'h1);
    check("R8 enable clear", irq, 0);
    rd(8'h00, v); check("R8 pending kept", v, 32'hA000_0001);
    @(negedge clk); irq_req = 0;
    @(negedge clk);
  endtask

  task automatic t_xfer;
    logic [31:0] v;
    wr(8'h00, 32'h10);
    wr(8'h04, 32'h0000_1000);
    @(negedge clk); xfer_done = 1; xfer_len = 16'h0020;
    @(negedge clk); xfer_done = 0;
    rd(8'h04, v); check("R9 advance", v, 32'h0000_1020);
    rd(8'h00, v); check("R9 pending", v[0], 1);
    check("R9 irq", irq, 1);
    @(negedge clk); xfer_done = 1; xfer_len = 16'hFFFF;
    @(negedge clk); xfer_done = 0;
    rd(8'h04, v); check("R9 wide len", v, 32'h0001_101F);
  endtask

  task automatic t_prio;
    logic [31:0] v;
    @(negedge clk);
    bus_wr = 1; bus_addr = 8'h04; bus_wdata = 32'h0000_5000;
    xfer_done = 1; xfer_len = 16'h0008;
    @(negedge clk); bus_wr = 0; xfer_done = 0;
    rd(8'h04, v); check("R10 write wins", v, 32'h0000_5000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_version();
    t_drain();
    t_devrst();
    t_loaded();
    t_irq();
    t_xfer();
    t_prio();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule